// File: doc/BRIEF.md
# Ping-Pong Attribute/Bitmap Strip Buffer

This block sits between a video memory fetch engine and a dot serialiser in a character-mode display pipeline. It holds two small banks, each covering one strip of character columns. At any time one bank is the fill bank and the other is the display bank. The fetch engine writes the fill bank while the serialiser reads the display bank. A swap pulse, given after the last pixel of a strip has gone out, exchanges the two roles.

Each column stores two bytes: an attribute and a bitmap. Each byte has its own write port, so attribute bursts and bitmap bursts can land independently and can even overlap. The display read port is combinational. It returns the attribute and the bitmap of the addressed column as one 16-bit word.

A side read port also returns, combinationally, the attribute byte of a column in the fill bank. The fetch engine uses it while writing bitmaps, because the attribute carries the extra code bit it needs to look up the font.

Top module: `strip_pingpong_buf`

## Requirements
- R1: Parameter STRIP_COLS selects 4, 8 or 16 columns per bank; column addresses are log2(STRIP_COLS) bits wide.
- R2: After synchronous reset `fill_sel_o` is 0, meaning bank 0 is the fill bank and bank 1 the display bank.
- R3: With `attr_we_i` high at a rising edge, the attribute byte of column `attr_waddr_i` in the fill bank takes `attr_wdata_i`; no bitmap byte changes.
- R4: With `bmp_we_i` high at a rising edge, the bitmap byte of column `bmp_waddr_i` in the fill bank takes `bmp_wdata_i`; no attribute byte changes.
- R5: `disp_pair_o` equals {attribute[15:8], bitmap[7:0]} of column `disp_raddr_i` in the display bank, combinationally from the address.
- R6: `side_attr_o` equals the attribute byte of column `side_raddr_i` in the fill bank, combinationally; a value written at an edge is visible right after that edge.
- R7: Writes never alter the display bank's contents.
- R8: A `swap_i` pulse inverts `fill_sel_o` at the next edge; without it `fill_sel_o` holds, and contents of both banks are preserved across a swap.
- R9: A write in the same cycle as a swap lands in the bank that was the fill bank before the swap, so it is visible on the display port afterwards.
- R10: Attribute and bitmap writes in the same cycle both take effect, including when they address the same column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_i | input | 1 | Exchange fill and display roles |
| attr_we_i | input | 1 | Attribute byte write enable |
| attr_waddr_i | input | log2(STRIP_COLS) | Attribute write column |
| attr_wdata_i | input | 8 | Attribute write data |
| bmp_we_i | input | 1 | Bitmap byte write enable |
| bmp_waddr_i | input | log2(STRIP_COLS) | Bitmap write column |
| bmp_wdata_i | input | 8 | Bitmap write data |
| side_raddr_i | input | log2(STRIP_COLS) | Fill-bank attribute read column |
| side_attr_o | output | 8 | Fill-bank attribute byte |
| disp_raddr_i | input | log2(STRIP_COLS) | Display read column |
| disp_pair_o | output | 16 | {attribute, bitmap} of display column |
| fill_sel_o | output | 1 | Index of the current fill bank |

## Verification
The bench targets a write and a swap in the same cycle. A design that applied the new select to the write would put the data in the bank now being shown and lose it from the next strip. It also aims attribute and bitmap writes at the same column in the same cycle. A shared write path there would drop one byte or copy the wrong byte over its neighbour. Random traffic with frequent swaps checks, every cycle, that the display bank never changes under fill writes and that the side port follows the fill bank rather than the display bank.

// File: rtl/strip_buf_pkg.sv
package strip_buf_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_BANKS = 2;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef struct packed {
    byte_t attr;
    byte_t bmp;
  } col_pair_t;
endpackage

// File: rtl/strip_byte_ram.sv
module strip_byte_ram #(
  parameter int DEPTH = 8,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  strip_buf_pkg::byte_t        wdata,
  input  logic [AW-1:0]               raddr,
  output strip_buf_pkg::byte_t        rdata
);
  strip_buf_pkg::byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R3/R4: a write lands in the addressed byte
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/strip_bank.sv
module strip_bank #(
  parameter int COLS = 8,
  parameter int AW = $clog2(COLS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        attr_we,
  input  logic [AW-1:0]               attr_waddr,
  input  strip_buf_pkg::byte_t        attr_wdata,
  input  logic                        bmp_we,
  input  logic [AW-1:0]               bmp_waddr,
  input  strip_buf_pkg::byte_t        bmp_wdata,
  input  logic [AW-1:0]               attr_raddr,
  input  logic [AW-1:0]               bmp_raddr,
  output strip_buf_pkg::byte_t        attr_rdata,
  output strip_buf_pkg::byte_t        bmp_rdata
);
  strip_byte_ram #(.DEPTH(COLS), .AW(AW)) u_attr_ram (
    .clk(clk), .rst(rst), .we(attr_we), .waddr(attr_waddr),
    .wdata(attr_wdata), .raddr(attr_raddr), .rdata(attr_rdata));

  strip_byte_ram #(.DEPTH(COLS), .AW(AW)) u_bmp_ram (
    .clk(clk), .rst(rst), .we(bmp_we), .waddr(bmp_waddr),
    .wdata(bmp_wdata), .raddr(bmp_raddr), .rdata(bmp_rdata));
endmodule

// File: rtl/strip_role_ctrl.sv
module strip_role_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic swap,
  output logic fill_sel
);
  always_ff @(posedge clk) begin
    if (rst)       fill_sel <= 1'b0;
    else if (swap) fill_sel <= ~fill_sel;
  end

  p_swap_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    swap |=> fill_sel != $past(fill_sel));
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(fill_sel));
endmodule

// File: rtl/strip_pingpong_buf.sv
module strip_pingpong_buf #(
  parameter int STRIP_COLS = 8,
  localparam int AW = $clog2(STRIP_COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_i,
  input  logic          attr_we_i,
  input  logic [AW-1:0] attr_waddr_i,
  input  logic [7:0]    attr_wdata_i,
  input  logic          bmp_we_i,
  input  logic [AW-1:0] bmp_waddr_i,
  input  logic [7:0]    bmp_wdata_i,
  input  logic [AW-1:0] side_raddr_i,
  output logic [7:0]    side_attr_o,
  input  logic [AW-1:0] disp_raddr_i,
  output logic [15:0]   disp_pair_o,
  output logic          fill_sel_o
);
  import strip_buf_pkg::*;

  initial begin
    p_width_legal_r1: assert (STRIP_COLS == 4 || STRIP_COLS == 8 || STRIP_COLS == 16);
  end

  logic  fill_sel;
  byte_t attr_rd [NUM_BANKS];
  byte_t bmp_rd  [NUM_BANKS];

  strip_role_ctrl u_role (.clk(clk), .rst(rst), .swap(swap_i), .fill_sel(fill_sel));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic is_fill;
    assign is_fill = (fill_sel == b[0]);
    strip_bank #(.COLS(STRIP_COLS), .AW(AW)) u_bank (
      .clk(clk), .rst(rst),
      .attr_we(attr_we_i && is_fill), .attr_waddr(attr_waddr_i), .attr_wdata(attr_wdata_i),
      .bmp_we(bmp_we_i && is_fill),   .bmp_waddr(bmp_waddr_i),   .bmp_wdata(bmp_wdata_i),
      .attr_raddr(is_fill ? side_raddr_i : disp_raddr_i),
      .bmp_raddr(disp_raddr_i),
      .attr_rdata(attr_rd[b]), .bmp_rdata(bmp_rd[b]));
  end

  col_pair_t disp_col;
  always_comb begin
    disp_col.attr = attr_rd[~fill_sel];
    disp_col.bmp  = bmp_rd[~fill_sel];
  end

  assign disp_pair_o = disp_col;
  assign side_attr_o = attr_rd[fill_sel];
  assign fill_sel_o  = fill_sel;

  // R7: display data is untouched while no swap occurs
  p_disp_isolated_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(swap_i) && !$past(rst) && $stable(disp_raddr_i)) |-> $stable(disp_pair_o));
  // R6: attribute write is visible on the side port right after the edge
  p_side_visible_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(attr_we_i) && !$past(swap_i) && !$past(rst) && side_raddr_i == $past(attr_waddr_i))
      |-> side_attr_o == $past(attr_wdata_i));
endmodule

// File: tb/strip_pingpong_buf_bench.sv
module strip_pingpong_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 8;
  localparam int AW = $clog2(COLS);

  logic clk = 0, rst = 1, swap_i = 0;
  logic attr_we_i = 0, bmp_we_i = 0;
  logic [AW-1:0] attr_waddr_i = '0, bmp_waddr_i = '0, side_raddr_i = '0, disp_raddr_i = '0;
  logic [7:0] attr_wdata_i = '0, bmp_wdata_i = '0;
  logic [7:0] side_attr_o;
  logic [15:0] disp_pair_o;
  logic fill_sel_o;

  int checks = 0, errors = 0;
  logic [7:0] m_attr [2][COLS];
  logic [7:0] m_bmp  [2][COLS];
  logic m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strip_pingpong_buf #(.STRIP_COLS(COLS)) u_strip_pingpong_buf (.*);

  function automatic logic [15:0] exp_pair(input logic [AW-1:0] a);
    return {m_attr[~m_sel][a], m_bmp[~m_sel][a]};
  endfunction
  function automatic logic [7:0] exp_side(input logic [AW-1:0] a);
    return m_attr[m_sel][a];
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: model follows the inputs held across the edge, then outputs are compared
  task automatic step(input string req);
    @(posedge clk);
    if (attr_we_i) m_attr[m_sel][attr_waddr_i] = attr_wdata_i;
    if (bmp_we_i)  m_bmp[m_sel][bmp_waddr_i]   = bmp_wdata_i;
    if (swap_i) m_sel = ~m_sel;
    @(negedge clk);
    attr_we_i = 0; bmp_we_i = 0; swap_i = 0;
    #1;
    chk({15'd0, fill_sel_o}, {15'd0, m_sel}, req);
    chk(disp_pair_o, exp_pair(disp_raddr_i), req);
    chk({8'd0, side_attr_o}, {8'd0, exp_side(side_raddr_i)}, req);
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < COLS; c++) begin
      disp_raddr_i = c[AW-1:0]; side_raddr_i = c[AW-1:0]; #1;
      chk(disp_pair_o, exp_pair(c[AW-1:0]), req);
      chk({8'd0, side_attr_o}, {8'd0, exp_side(c[AW-1:0])}, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0; #1;
    chk({15'd0, fill_sel_o}, 16'd0, "R2 reset select");
    // R1: fill every column of both banks
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < COLS; c++) begin
        attr_we_i = 1; attr_waddr_i = c[AW-1:0]; attr_wdata_i = 8'($urandom);
        bmp_we_i = 1;  bmp_waddr_i = c[AW-1:0];  bmp_wdata_i = 8'($urandom);
        step("R1 fill");
      end
      swap_i = 1; step("R8 swap");
    end
    sweep("R5 R6 initial sweep");
    // R3: attribute-only write
    attr_we_i = 1; attr_waddr_i = 3; attr_wdata_i = 8'hA5; side_raddr_i = 3;
    step("R3 attr only");
    chk({8'd0, side_attr_o}, 16'h00A5, "R6 side visible");
    // R4: bitmap-only write, side keeps attribute
    bmp_we_i = 1; bmp_waddr_i = 3; bmp_wdata_i = 8'h3C;
    step("R4 bitmap only");
    chk({8'd0, side_attr_o}, 16'h00A5, "R4 attr kept");
    // R10: both halves same column same cycle
    attr_we_i = 1; attr_waddr_i = 5; attr_wdata_i = 8'h81;
    bmp_we_i = 1;  bmp_waddr_i = 5;  bmp_wdata_i = 8'h7E;
    step("R10 same column");
    // R9: write together with swap goes to old fill bank
    attr_we_i = 1; attr_waddr_i = 6; attr_wdata_i = 8'hC3;
    bmp_we_i = 1;  bmp_waddr_i = 6;  bmp_wdata_i = 8'h18;
    swap_i = 1; disp_raddr_i = 6;
    step("R9 write with swap");
    chk(disp_pair_o, 16'hC318, "R9 displayed");
    swap_i = 1; disp_raddr_i = 3; step("R8 swap back");
    swap_i = 1; step("R8 swap again");
    chk(disp_pair_o, 16'hA53C, "R3 R4 R5 pair");
    swap_i = 1; disp_raddr_i = 5; step("R8 swap");
    swap_i = 1; step("R8 swap");
    chk(disp_pair_o, 16'h817E, "R10 pair");
    sweep("R7 R8 sweep after swaps");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      attr_we_i = 1'($urandom); attr_waddr_i = AW'($urandom); attr_wdata_i = 8'($urandom);
      bmp_we_i  = 1'($urandom); bmp_waddr_i  = AW'($urandom); bmp_wdata_i  = 8'($urandom);
      swap_i = ($urandom % 6) == 0;
      disp_raddr_i = AW'($urandom); side_raddr_i = AW'($urandom);
      step("R7 random");
    end
    sweep("R5 R6 final sweep");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule